// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital sequencer of a successive-approximation analog-to-digital converter. It runs on the system clock and moves forward only on cycles where the conversion-clock enable `tad_en` is high. That enable is high for one cycle per conversion period, TAD. Software starts a conversion by writing the control word with the start/busy bit set. The 3-bit acquisition select in the same write sets how many TAD the block first spends sampling with the hold switch closed. The block then opens the hold switch and resolves the result from the most significant bit down. It drives a trial code to the DAC and reads one comparator bit back.

When the last bit is resolved, the block does three things on the same clock edge: it loads the result register, clears the busy bit and raises the interrupt flag. Software can also clear the busy bit while a conversion runs. This abandons the conversion and leaves the result register as it was. After either ending, the block holds the switch closed for a fixed 2-TAD recovery. A start written during that recovery is kept and begins once the recovery ends.

Top module: `sar_adc_sequencer`

## Requirements
- R1: With acquisition select 000, a control write with `ctl_go`=1 from idle opens the hold switch (`hold_open`=1) on the following clock edge. No acquisition TAD is counted, and `dac_code` is 10'h200 at that point.
- R2: With acquisition select 010, `hold_open` stays 0 and `busy` stays 1 for the first three `tad_en` pulses after the start. `hold_open` becomes 1 on the edge of the fourth pulse.
- R3: `hold_open` is 1 exactly while a conversion runs. It returns to 0 on the completion edge or the abort edge.
- R4: A conversion takes 11 `tad_en` pulses: one initial pulse, then one per result bit. `busy` is still 1 after the tenth pulse and goes to 0 on the eleventh.
- R5: On the completion edge, `result` takes the converted code, `busy` becomes 0 and `irq_flag` becomes 1, all together.
- R6: Each step sets the bit under trial in `dac_code`. If `cmp_below`=1 (input below the DAC level) the bit is cleared, otherwise it is kept. So `result` equals the input code of an ideal comparator.
- R7: Acquisition select codes 001, 011, 100, 101, 110 and 111 give 2, 6, 8, 12, 16 and 20 TAD of acquisition. The conversion starts on the last of those pulses.
- R8: A control write with `ctl_go`=0 during acquisition or conversion clears `busy` and closes the hold switch. It leaves `result` and `irq_flag` untouched, and `result` keeps either the last completed code or the last value written through `res_wr`.
- R9: After a completion or an abort, `hold_open` stays 0 for two `tad_en` pulses, even when a start is pending.
- R10: A start written during the recovery reads back as `busy`=1. It begins on the edge of the second recovery pulse, with the acquisition select then in force.
- R11: `flag_w1c`=1 clears `irq_flag`. `flag_wr` loads `flag_wdata` into it.
- R12: On the same edge, a hardware completion wins over a software flag clear, leaving `irq_flag`=1. It also wins over an abort write, so the result is loaded.
- R13: A start write while a conversion runs does not restart or lengthen it. The conversion still completes on its eleventh pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tad_en | input | 1 | One-cycle pulse per conversion period (TAD) |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_go | input | 1 | Start/busy bit value written (1 start, 0 abort) |
| ctl_acq_sel | input | 3 | Acquisition-time select written |
| res_wr | input | 1 | Software write strobe for the result register |
| res_wdata | input | 10 | Software result value |
| flag_wr | input | 1 | Direct write strobe for the interrupt flag |
| flag_wdata | input | 1 | Value for the direct flag write |
| flag_w1c | input | 1 | Write-one-to-clear of the interrupt flag |
| cmp_below | input | 1 | Comparator: analog input is below the DAC level |
| busy | output | 1 | Start/busy bit readback |
| acq_sel | output | 3 | Acquisition select readback |
| result | output | 10 | Result register |
| irq_flag | output | 1 | Completion interrupt flag |
| hold_open | output | 1 | 1 = holding capacitor disconnected from input |
| dac_code | output | 10 | Trial code to the DAC |

## Verification
The hardware completion can land on the same edge as a software write. That write may be a flag clear, or a control write that aborts. The bench runs a conversion to its tenth pulse. It then drives the eleventh `tad_en` pulse together with `flag_w1c`, and in a second run together with `ctl_wr`/`ctl_go`=0. After that edge it expects `irq_flag`=1 and `result` equal to the converted code. A second overlap is a start written during the recovery. The bench checks that `hold_open` stays low through both recovery pulses and rises on the second.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int SEL_W = 3;
  localparam int ACQ_W = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2,
    ST_WAIT = 2'd3
  } sar_state_e;

  // acquisition length in TAD for each select code
  function automatic logic [ACQ_W-1:0] acq_tads(input logic [SEL_W-1:0] sel);
    logic [ACQ_W-1:0] n;
    case (sel)
      3'd0:    n = ACQ_W'(0);
      3'd1:    n = ACQ_W'(2);
      3'd2:    n = ACQ_W'(4);
      3'd3:    n = ACQ_W'(6);
      3'd4:    n = ACQ_W'(8);
      3'd5:    n = ACQ_W'(12);
      3'd6:    n = ACQ_W'(16);
      default: n = ACQ_W'(20);
    endcase
    return n;
  endfunction
endpackage

// File: rtl/sar_tad_counter.sv
module sar_tad_counter #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  input  logic         tad_en,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt_q, cnt_d;

  assign hit = run && tad_en && (cnt_q == limit - 1'b1);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                cnt_d = '0;
    else if (run && tad_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // the window counter never runs past the programmed length
  assert_cnt_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < limit));
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int BITS = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            run,
  input  logic            tad_en,
  input  logic            cmp_below,
  output logic [BITS-1:0] code,
  output logic [BITS-1:0] final_code,
  output logic            done
);
  localparam int STEP_W = $clog2(BITS + 1);

  logic [STEP_W-1:0] step_q, step_d;
  logic [BITS-1:0]   code_q, code_d;
  logic [BITS-1:0]   trial_mask, next_mask, resolved;

  // step k (1..BITS) decides bit BITS-k; step 0 is the initial TAD
  always_comb begin
    for (int i = 0; i < BITS; i++) begin
      trial_mask[i] = (int'(step_q) == BITS - i);
      next_mask[i]  = (int'(step_q) == BITS - 1 - i);
    end
  end

  assign resolved   = cmp_below ? (code_q & ~trial_mask) : code_q;
  assign done       = run && tad_en && (int'(step_q) == BITS);
  assign final_code = resolved;
  assign code       = code_q;

  always_comb begin
    step_d = step_q;
    code_d = code_q;
    if (load) begin
      step_d = '0;
      code_d = {1'b1, {(BITS-1){1'b0}}};
    end else if (run && tad_en && (int'(step_q) != BITS)) begin
      step_d = step_q + 1'b1;
      if (step_q != '0) code_d = resolved | next_mask;
    end else if (done) begin
      code_d = resolved;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      code_q <= '0;
    end else begin
      step_q <= step_d;
      code_q <= code_d;
    end
  end

  assert_step_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(step_q) <= BITS);
  assert_msb_trial_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (code_q == {1'b1, {(BITS-1){1'b0}}}));
endmodule

// File: rtl/sar_status_regs.sv
module sar_status_regs #(
  parameter int BITS = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hw_done,
  input  logic [BITS-1:0] done_code,
  input  logic            sw_res_wr,
  input  logic [BITS-1:0] sw_res_data,
  input  logic            flag_wr,
  input  logic            flag_wdata,
  input  logic            flag_w1c,
  output logic [BITS-1:0] result,
  output logic            flag
);
  logic [BITS-1:0] res_q, res_d;
  logic            flag_q, flag_d;

  always_comb begin
    res_d = res_q;
    if (hw_done)        res_d = done_code;
    else if (sw_res_wr) res_d = sw_res_data;
  end

  always_comb begin
    flag_d = flag_q;
    if (hw_done)       flag_d = 1'b1;
    else if (flag_wr)  flag_d = flag_wdata;
    else if (flag_w1c) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      flag_q <= flag_d;
    end
  end

  assign result = res_q;
  assign flag   = flag_q;

  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    hw_done |=> flag_q);
  assert_result_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_done && !sw_res_wr) |=> $stable(res_q));
endmodule

// File: rtl/sar_adc_sequencer.sv
module sar_adc_sequencer
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS  = 10,
  parameter int WAIT_TADS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tad_en,
  input  logic                ctl_wr,
  input  logic                ctl_go,
  input  logic [SEL_W-1:0]    ctl_acq_sel,
  input  logic                res_wr,
  input  logic [RES_BITS-1:0] res_wdata,
  input  logic                flag_wr,
  input  logic                flag_wdata,
  input  logic                flag_w1c,
  input  logic                cmp_below,
  output logic                busy,
  output logic [SEL_W-1:0]    acq_sel,
  output logic [RES_BITS-1:0] result,
  output logic                irq_flag,
  output logic                hold_open,
  output logic [RES_BITS-1:0] dac_code
);
  sar_state_e          state_q, state_d;
  logic                go_q, go_d;
  logic [SEL_W-1:0]    sel_q, sel_d;
  logic [ACQ_W-1:0]    acq_len_q, acq_len_d, start_len, cnt_limit;
  logic                start_req, abort_req, cnt_hit, cnt_run, cnt_clr;
  logic                conv_load, conv_run, conv_done;
  logic [RES_BITS-1:0] conv_code;

  assign sel_d     = ctl_wr ? ctl_acq_sel : sel_q;
  assign start_len = acq_tads(sel_d);
  assign start_req = ctl_wr && ctl_go;
  assign abort_req = ctl_wr && !ctl_go;

  always_comb begin
    state_d   = state_q;
    go_d      = go_q;
    acq_len_d = acq_len_q;
    conv_load = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_req) begin
          go_d      = 1'b1;
          acq_len_d = start_len;
          if (start_len == '0) begin
            state_d   = ST_CONV;
            conv_load = 1'b1;
          end else begin
            state_d = ST_ACQ;
          end
        end
      end
      ST_ACQ: begin
        if (abort_req) begin
          go_d    = 1'b0;
          state_d = ST_WAIT;
        end else if (cnt_hit) begin
          state_d   = ST_CONV;
          conv_load = 1'b1;
        end
      end
      ST_CONV: begin
        if (conv_done || abort_req) begin
          go_d    = 1'b0;
          state_d = ST_WAIT;
        end
      end
      default: begin
        if (ctl_wr) go_d = ctl_go;
        if (cnt_hit) begin
          if (go_d) begin
            acq_len_d = start_len;
            if (start_len == '0) begin
              state_d   = ST_CONV;
              conv_load = 1'b1;
            end else begin
              state_d = ST_ACQ;
            end
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      go_q      <= 1'b0;
      sel_q     <= '0;
      acq_len_q <= '0;
    end else begin
      state_q   <= state_d;
      go_q      <= go_d;
      sel_q     <= sel_d;
      acq_len_q <= acq_len_d;
    end
  end

  assign cnt_run   = (state_q == ST_ACQ) || (state_q == ST_WAIT);
  assign cnt_clr   = (state_d != state_q);
  assign cnt_limit = (state_q == ST_WAIT) ? ACQ_W'(WAIT_TADS) : acq_len_q;
  assign conv_run  = (state_q == ST_CONV);

  sar_tad_counter #(.W(ACQ_W)) u_tad_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (cnt_clr),
    .run    (cnt_run),
    .tad_en (tad_en),
    .limit  (cnt_limit),
    .hit    (cnt_hit)
  );

  sar_bit_engine #(.BITS(RES_BITS)) u_bits (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (conv_load),
    .run        (conv_run),
    .tad_en     (tad_en),
    .cmp_below  (cmp_below),
    .code       (dac_code),
    .final_code (conv_code),
    .done       (conv_done)
  );

  sar_status_regs #(.BITS(RES_BITS)) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_done     (conv_done),
    .done_code   (conv_code),
    .sw_res_wr   (res_wr),
    .sw_res_data (res_wdata),
    .flag_wr     (flag_wr),
    .flag_wdata  (flag_wdata),
    .flag_w1c    (flag_w1c),
    .result      (result),
    .flag        (irq_flag)
  );

  assign busy      = go_q;
  assign acq_sel   = sel_q;
  assign hold_open = conv_run;

  assert_open_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_open |-> busy);
  assert_done_updates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (!busy && irq_flag && !hold_open));
  assert_wait_no_early_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !tad_en) |=> (state_q == ST_WAIT));
  assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_req && busy && !conv_done) |=> (!busy && !hold_open));
endmodule

// File: tb/sar_adc_sequencer_bench.sv
module sar_adc_sequencer_bench;
  logic       clk, rst_n, tad_en;
  logic       ctl_wr, ctl_go;
  logic [2:0] ctl_acq_sel;
  logic       res_wr;
  logic [9:0] res_wdata;
  logic       flag_wr, flag_wdata, flag_w1c;
  logic       cmp_below;
  logic       busy, irq_flag, hold_open;
  logic [2:0] acq_sel;
  logic [9:0] result, dac_code;
  logic [9:0] vin;
  int checks = 0;
  int errors = 0;

  sar_adc_sequencer u_sar_adc_sequencer (
    .clk(clk), .rst_n(rst_n), .tad_en(tad_en),
    .ctl_wr(ctl_wr), .ctl_go(ctl_go), .ctl_acq_sel(ctl_acq_sel),
    .res_wr(res_wr), .res_wdata(res_wdata),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata), .flag_w1c(flag_w1c),
    .cmp_below(cmp_below),
    .busy(busy), .acq_sel(acq_sel), .result(result), .irq_flag(irq_flag),
    .hold_open(hold_open), .dac_code(dac_code)
  );

  // ideal comparator
  assign cmp_below = (vin < dac_code);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tad(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tad_en = 1'b1;
      @(negedge clk) tad_en = 1'b0;
    end
  endtask

  task automatic ctl_write(input logic go, input logic [2:0] sel);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_go = go; ctl_acq_sel = sel;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic flag_clear();
    @(negedge clk) flag_w1c = 1'b1;
    @(negedge clk) flag_w1c = 1'b0;
  endtask

  task automatic t_reset();
    chk("R5 reset busy", busy, 0);
    chk("R5 reset flag", irq_flag, 0);
    chk("R5 reset result", result, 0);
    chk("R3 reset hold", hold_open, 0);
  endtask

  task automatic t_direct();
    vin = 10'h2A5;
    ctl_write(1'b1, 3'd0);
    chk("R1 hold opens at once", hold_open, 1);
    chk("R1 msb trial", dac_code, 10'h200);
    tad(10);
    chk("R4 busy after 10 TAD", busy, 1);
    chk("R3 hold open after 10 TAD", hold_open, 1);
    tad(1);
    chk("R5 busy cleared", busy, 0);
    chk("R5 flag set", irq_flag, 1);
    chk("R6 result", result, 10'h2A5);
    chk("R3 hold closed", hold_open, 0);
    tad(2);
  endtask

  task automatic t_acq4();
    flag_clear();
    chk("R11 w1c clears flag", irq_flag, 0);
    vin = 10'h0F3;
    ctl_write(1'b1, 3'b010);
    chk("R2 hold closed at start", hold_open, 0);
    tad(3);
    chk("R2 hold closed after 3", hold_open, 0);
    chk("R2 busy during acq", busy, 1);
    tad(1);
    chk("R2 hold open after 4", hold_open, 1);
    tad(11);
    chk("R6 result acq4", result, 10'h0F3);
    chk("R5 flag acq4", irq_flag, 1);
    tad(2);
  endtask

  task automatic t_codes();
    int lens[6] = '{2, 6, 8, 12, 16, 20};
    logic [2:0] sels[6] = '{3'd1, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
    flag_clear();
    vin = 10'h3FF;
    for (int k = 0; k < 6; k++) begin
      ctl_write(1'b1, sels[k]);
      tad(lens[k] - 1);
      chk($sformatf("R7 code %0d closed before end", sels[k]), hold_open, 0);
      tad(1);
      chk($sformatf("R7 code %0d opens on last", sels[k]), hold_open, 1);
      tad(3);
      ctl_write(1'b0, sels[k]);
      chk("R8 abort clears busy", busy, 0);
      chk("R8 abort closes hold", hold_open, 0);
      tad(2);
    end
    chk("R8 result kept after aborts", result, 10'h0F3);
    chk("R8 no flag after aborts", irq_flag, 0);
  endtask

  task automatic t_sw_result_abort();
    @(negedge clk) begin res_wr = 1'b1; res_wdata = 10'h155; end
    @(negedge clk) res_wr = 1'b0;
    vin = 10'h011;
    ctl_write(1'b1, 3'b010);
    tad(2);
    ctl_write(1'b0, 3'b010);
    chk("R8 abort in acq busy", busy, 0);
    tad(2);
    ctl_write(1'b1, 3'd0);
    tad(5);
    ctl_write(1'b0, 3'd0);
    tad(2);
    chk("R8 sw result kept", result, 10'h155);
    chk("R8 flag untouched", irq_flag, 0);
  endtask

  task automatic t_wait_pending();
    vin = 10'h1C4;
    ctl_write(1'b1, 3'd0);
    tad(11);
    chk("R6 result before pending", result, 10'h1C4);
    vin = 10'h0AA;
    ctl_write(1'b1, 3'd0);
    chk("R10 pending reads busy", busy, 1);
    chk("R9 hold closed in wait", hold_open, 0);
    tad(1);
    chk("R9 hold closed after 1 wait TAD", hold_open, 0);
    tad(1);
    chk("R10 pending start opens hold", hold_open, 1);
    tad(11);
    chk("R10 pending result", result, 10'h0AA);
    tad(2);
  endtask

  task automatic t_ignored_start();
    vin = 10'h301;
    ctl_write(1'b1, 3'd0);
    tad(4);
    ctl_write(1'b1, 3'd7);
    chk("R13 still converting", hold_open, 1);
    tad(6);
    chk("R13 busy after 10", busy, 1);
    tad(1);
    chk("R13 done on 11th", busy, 0);
    chk("R13 result", result, 10'h301);
    tad(2);
  endtask

  task automatic t_flag();
    @(negedge clk) begin flag_wr = 1'b1; flag_wdata = 1'b0; end
    @(negedge clk) flag_wr = 1'b0;
    chk("R11 direct write 0", irq_flag, 0);
    @(negedge clk) begin flag_wr = 1'b1; flag_wdata = 1'b1; end
    @(negedge clk) flag_wr = 1'b0;
    chk("R11 direct write 1", irq_flag, 1);
    flag_clear();
    vin = 10'h07E;
    ctl_write(1'b1, 3'd0);
    tad(10);
    @(negedge clk) begin tad_en = 1'b1; flag_w1c = 1'b1; end
    @(negedge clk) begin tad_en = 1'b0; flag_w1c = 1'b0; end
    chk("R12 set wins over clear", irq_flag, 1);
    chk("R12 result with clear", result, 10'h07E);
    tad(2);
    flag_clear();
    vin = 10'h2E1;
    ctl_write(1'b1, 3'd0);
    tad(10);
    @(negedge clk) begin tad_en = 1'b1; ctl_wr = 1'b1; ctl_go = 1'b0; end
    @(negedge clk) begin tad_en = 1'b0; ctl_wr = 1'b0; end
    chk("R12 completion wins over abort", result, 10'h2E1);
    chk("R12 flag on completion vs abort", irq_flag, 1);
    chk("R12 busy cleared", busy, 0);
    tad(2);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tad_en = 1'b0; ctl_wr = 1'b0; ctl_go = 1'b0; ctl_acq_sel = '0;
    res_wr = 1'b0; res_wdata = '0; flag_wr = 1'b0; flag_wdata = 1'b0;
    flag_w1c = 1'b0; vin = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_acq4();
    t_codes();
    t_sw_result_abort();
    t_wait_pending();
    t_ignored_start();
    t_flag();
    finish_run();
  end
endmodule